// File: doc/BRIEF.md
# 64-bit Register Shift Unit

This block performs every shift form needed by a 64-bit integer datapath: logical left, logical right and arithmetic right, in both a 32-bit word width and a full 64-bit doubleword width. Word forms work only on the low half of the operand and widen their 32-bit result to 64 bits by copying bit 31. Doubleword forms work on all 64 bits.

The shift amount comes from one of three places. It can be a 5-bit immediate, taken as is. It can be a 5-bit immediate with 32 added, which reaches amounts 32 to 63 in doubleword forms only. It can also be the low bits of an amount register: five bits for word forms and six bits for doubleword forms. A 4-bit operation code selects one of fifteen forms. The result is registered, and a valid strobe follows the input strobe by exactly one clock.

Top module: `dword_shifter`

## Requirements
- R1: Word forms (codes 0 to 5) use only operand bits [31:0]. The 64-bit result is the 32-bit shift result sign-extended from its bit 31, and operand bits [63:32] have no effect.
- R2: Word logical right shifts fill with zeros inside the 32-bit word before sign extension. A shift of 0 with operand bit 31 set gives a result whose upper 32 bits are all ones.
- R3: Variable word forms (codes 3, 4, 5) take the amount from amtReg[4:0], and amtReg bits above bit 4 have no effect.
- R4: Variable doubleword forms (codes 12, 13, 14) take the amount from amtReg[5:0], and amtReg bits above bit 5 have no effect.
- R5: Immediate doubleword forms (codes 6, 7, 8) shift by immAmt (0 to 31). The plus-32 forms (codes 9, 10, 11) shift by 32 + immAmt (32 to 63).
- R6: Doubleword arithmetic right shifts fill with copies of bit 63. Logical right shifts fill with zeros, and left shifts fill with zeros from bit 0.
- R7: Code map: 0/1/2 are word immediate left/logical-right/arithmetic-right. 3/4/5 are the same three word forms with a register amount. 6/7/8 are doubleword immediate. 9/10/11 are doubleword plus-32. 12/13/14 are doubleword register-amount. Each group of three is ordered left, logical right, arithmetic right.
- R8: outValid is high in exactly the cycle after a cycle with inValid high. The result of that operation is present on `result` in that same cycle.
- R9: The unused code 15 yields a result of zero.
- R10: Reset clears outValid and result to zero. While inValid is low, result holds its last value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation request strobe |
| opCode | input | 4 | Shift form selector |
| operand | input | 64 | Value to be shifted |
| immAmt | input | 5 | Immediate shift amount |
| amtReg | input | 64 | Register supplying a variable amount |
| outValid | output | 1 | Result valid, one cycle after inValid |
| result | output | 64 | Registered shift result |

## Verification
The hardest cases to reach are the ones where a bit that should be ignored carries meaning. One is amount-register bits just above the masked field, such as bit 5 for word forms, which would double a shift if decoded. Another is a word logical right shift of zero with bit 31 set, where the sign extension must still turn the result negative. The stimulus reaches these with directed vectors whose amount registers have the neighbouring bits set and whose operands have junk in the upper half. A loop then drives every code at amounts 0, 1, 31, 32 and 63 with random operands and random upper amount-register bits, and compares each result with an independent model.

// File: rtl/shift_pkg.sv
package shift_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_W_SLL_I   = 4'd0,
    OP_W_SRL_I   = 4'd1,
    OP_W_SRA_I   = 4'd2,
    OP_W_SLL_R   = 4'd3,
    OP_W_SRL_R   = 4'd4,
    OP_W_SRA_R   = 4'd5,
    OP_D_SLL_I   = 4'd6,
    OP_D_SRL_I   = 4'd7,
    OP_D_SRA_I   = 4'd8,
    OP_D_SLL_P32 = 4'd9,
    OP_D_SRL_P32 = 4'd10,
    OP_D_SRA_P32 = 4'd11,
    OP_D_SLL_R   = 4'd12,
    OP_D_SRL_R   = 4'd13,
    OP_D_SRA_R   = 4'd14,
    OP_UNUSED    = 4'd15
  } shiftOpE;

  // Strobes from control to datapath
  typedef struct packed {
    logic legal;    // code selects a real form
    logic isWord;   // 32-bit form with sign extension
    logic toRight;  // right shift
    logic arith;    // replicate sign on right shift
    logic useReg;   // amount from register
    logic plus32;   // add word width to immediate
  } shiftCtrlT;

endpackage

// File: rtl/shift_barrel.sv
// Logarithmic right shifter with a selectable fill bit.
module shift_barrel #(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  logic              fill,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] stage [AMT_W+1];

  assign stage[0] = din;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][DATA_W-1:STEP]}
                               : stage[s];
  end

  assign dout = stage[AMT_W];

endmodule

// File: rtl/shift_ctrl.sv
// Decodes the operation code into datapath strobes.
module shift_ctrl
  import shift_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output shiftCtrlT       ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.legal = 1'b1;
    case (shiftOpE'(opCode))
      OP_W_SLL_I:   begin ctrl.isWord = 1'b1; end
      OP_W_SRL_I:   begin ctrl.isWord = 1'b1; ctrl.toRight = 1'b1; end
      OP_W_SRA_I:   begin ctrl.isWord = 1'b1; ctrl.toRight = 1'b1; ctrl.arith = 1'b1; end
      OP_W_SLL_R:   begin ctrl.isWord = 1'b1; ctrl.useReg = 1'b1; end
      OP_W_SRL_R:   begin ctrl.isWord = 1'b1; ctrl.useReg = 1'b1; ctrl.toRight = 1'b1; end
      OP_W_SRA_R:   begin ctrl.isWord = 1'b1; ctrl.useReg = 1'b1; ctrl.toRight = 1'b1;
                          ctrl.arith = 1'b1; end
      OP_D_SLL_I:   begin end
      OP_D_SRL_I:   begin ctrl.toRight = 1'b1; end
      OP_D_SRA_I:   begin ctrl.toRight = 1'b1; ctrl.arith = 1'b1; end
      OP_D_SLL_P32: begin ctrl.plus32 = 1'b1; end
      OP_D_SRL_P32: begin ctrl.plus32 = 1'b1; ctrl.toRight = 1'b1; end
      OP_D_SRA_P32: begin ctrl.plus32 = 1'b1; ctrl.toRight = 1'b1; ctrl.arith = 1'b1; end
      OP_D_SLL_R:   begin ctrl.useReg = 1'b1; end
      OP_D_SRL_R:   begin ctrl.useReg = 1'b1; ctrl.toRight = 1'b1; end
      OP_D_SRA_R:   begin ctrl.useReg = 1'b1; ctrl.toRight = 1'b1; ctrl.arith = 1'b1; end
      default:      begin ctrl = '0; end
    endcase
  end

endmodule

// File: rtl/shift_datapath.sv
// Amount selection, operand preparation, shifting and the output register.
module shift_datapath
  import shift_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int IMM_W  = 5,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int WAMT_W = $clog2(WORD_W),
  localparam int HI_W   = DATA_W - WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  shiftCtrlT         ctrl,
  input  logic [DATA_W-1:0] operand,
  input  logic [IMM_W-1:0]  immAmt,
  input  logic [DATA_W-1:0] amtReg,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);

  logic [AMT_W-1:0]  amt;
  logic              fillBit;
  logic [DATA_W-1:0] preOp;
  logic [DATA_W-1:0] revIn;
  logic [DATA_W-1:0] barrelIn;
  logic [DATA_W-1:0] barrelOut;
  logic [DATA_W-1:0] revOut;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] nextRes;
  logic [DATA_W-1:0] resultQ;
  logic              validQ;
  logic              wordQ;

  // Amount: register field masked by form width, or immediate (+word width)
  always_comb begin
    if (ctrl.useReg) begin
      if (ctrl.isWord) amt = AMT_W'(amtReg[WAMT_W-1:0]);
      else             amt = amtReg[AMT_W-1:0];
    end else begin
      amt = AMT_W'(immAmt) + (ctrl.plus32 ? AMT_W'(WORD_W) : '0);
    end
  end

  // Word forms: the upper half becomes the fill so right shifts stay in-word
  assign fillBit = ctrl.toRight & ctrl.arith &
                   (ctrl.isWord ? operand[WORD_W-1] : operand[DATA_W-1]);
  assign preOp   = ctrl.isWord ? {{HI_W{fillBit}}, operand[WORD_W-1:0]} : operand;

  // Left shifts reuse the right shifter between two bit reversals
  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign revIn[b]  = preOp[DATA_W-1-b];
    assign revOut[b] = barrelOut[DATA_W-1-b];
  end

  assign barrelIn = ctrl.toRight ? preOp : revIn;

  shift_barrel #(.DATA_W(DATA_W)) u_barrel (
    .din  (barrelIn),
    .amt  (amt),
    .fill (fillBit),
    .dout (barrelOut)
  );

  assign shifted = ctrl.toRight ? barrelOut : revOut;

  always_comb begin
    if (!ctrl.legal)      nextRes = '0;
    else if (ctrl.isWord) nextRes = {{HI_W{shifted[WORD_W-1]}}, shifted[WORD_W-1:0]};
    else                  nextRes = shifted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      resultQ <= '0;
      wordQ   <= 1'b0;
    end else begin
      validQ <= inValid;
      if (inValid) begin
        resultQ <= nextRes;
        wordQ   <= ctrl.legal & ctrl.isWord;
      end
    end
  end

  assign outValid = validQ;
  assign result   = resultQ;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R8
  AST_WORD_SIGN_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && wordQ) |-> (result[DATA_W-1:WORD_W] == {HI_W{result[WORD_W-1]}})); // R1
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ctrl.legal) |=> (result == '0)); // R9
  AST_DWORD_SRA_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctrl.legal && !ctrl.isWord && ctrl.toRight && ctrl.arith)
      |=> (result[DATA_W-1] == $past(operand[DATA_W-1]))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result)); // R10

endmodule

// File: rtl/dword_shifter.sv
module dword_shifter
  import shift_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] operand,
  input  logic [IMM_W-1:0]  immAmt,
  input  logic [DATA_W-1:0] amtReg,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);

  shiftCtrlT ctrl;

  shift_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  shift_datapath #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W),
    .IMM_W  (IMM_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .operand  (operand),
    .immAmt   (immAmt),
    .amtReg   (amtReg),
    .outValid (outValid),
    .result   (result)
  );

endmodule

// File: tb/tb_dword_shifter.sv
module tb_dword_shifter;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [63:0] operand = '0;
  logic [4:0]  immAmt = '0;
  logic [63:0] amtReg = '0;
  logic        outValid;
  logic [63:0] result;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dword_shifter dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .operand(operand), .immAmt(immAmt), .amtReg(amtReg),
    .outValid(outValid), .result(result)
  );

  // Directed vector table: code, operand, immediate, amount register, expected
  localparam logic [3:0]  T_OP  [NVEC] = '{4'd1, 4'd1, 4'd0, 4'd2, 4'd11, 4'd10,
                                           4'd12, 4'd3, 4'd3, 4'd15, 4'd6, 4'd7, 4'd9};
  localparam logic [63:0] T_X   [NVEC] = '{64'h0000_0000_8000_0000, 64'h1234_5678_8000_0000,
                                           64'h1, 64'h0000_0000_8000_0000,
                                           64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
                                           64'h1, 64'h1, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF,
                                           64'hF, 64'h8000_0000_0000_0000, 64'h1};
  localparam logic [4:0]  T_IMM [NVEC] = '{5'd0, 5'd1, 5'd31, 5'd4, 5'd31, 5'd31,
                                           5'd0, 5'd0, 5'd0, 5'd7, 5'd4, 5'd0, 5'd0};
  localparam logic [63:0] T_A   [NVEC] = '{64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
                                           64'hFF, 64'h3F, 64'h20, 64'hFF, 64'h0, 64'h0, 64'h0};
  localparam logic [63:0] T_EXP [NVEC] = '{64'hFFFF_FFFF_8000_0000, 64'h0000_0000_4000_0000,
                                           64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_F800_0000,
                                           64'hFFFF_FFFF_FFFF_FFFF, 64'h1,
                                           64'h8000_0000_0000_0000, 64'hFFFF_FFFF_8000_0000,
                                           64'h1, 64'h0, 64'hF0, 64'h8000_0000_0000_0000,
                                           64'h1_0000_0000};

  function automatic string tagOf(int i);
    case (i)
      0: return "R2";
      1, 2, 3: return "R1";
      4, 11: return "R6";
      5, 10, 12: return "R5";
      6: return "R4";
      7, 8: return "R3";
      default: return "R9";
    endcase
  endfunction

  // Independent model written from the requirements
  function automatic logic [63:0] modelShift(logic [3:0] op, logic [63:0] x,
                                             logic [4:0] imm, logic [63:0] a);
    logic [31:0] w;
    logic [63:0] d;
    w = '0;
    d = '0;
    case (op)
      4'd0:  w = x[31:0] << imm;
      4'd1:  w = x[31:0] >> imm;
      4'd2:  w = $signed(x[31:0]) >>> imm;
      4'd3:  w = x[31:0] << a[4:0];
      4'd4:  w = x[31:0] >> a[4:0];
      4'd5:  w = $signed(x[31:0]) >>> a[4:0];
      4'd6:  d = x << imm;
      4'd7:  d = x >> imm;
      4'd8:  d = $signed(x) >>> imm;
      4'd9:  d = x << (32 + imm);
      4'd10: d = x >> (32 + imm);
      4'd11: d = $signed(x) >>> (32 + imm);
      4'd12: d = x << a[5:0];
      4'd13: d = x >> a[5:0];
      4'd14: d = $signed(x) >>> a[5:0];
      default: d = '0;
    endcase
    if (op <= 4'd5) return {{32{w[31]}}, w};
    return d;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one request; sample one cycle after the capturing edge
  task automatic apply(logic [3:0] op, logic [63:0] x, logic [4:0] imm,
                       logic [63:0] a, output logic [63:0] got, output logic v);
    @(negedge clk);
    opCode = op; operand = x; immAmt = imm; amtReg = a; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    got = result;
    v = outValid;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    logic [63:0] got;
    logic        v;
    logic [63:0] held;
    int          amts [5] = '{0, 1, 31, 32, 63};

    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset valid", {63'b0, outValid}, 64'h0);
    check("R10 reset result", result, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed table
    for (int i = 0; i < NVEC; i++) begin
      apply(T_OP[i], T_X[i], T_IMM[i], T_A[i], got, v);
      check(tagOf(i), got, T_EXP[i]);
    end

    // R8: valid strobe one cycle after request, then low
    apply(4'd6, 64'h3, 5'd1, 64'h0, got, v);
    check("R8 valid high", {63'b0, v}, 64'h1);
    check("R8 result", got, 64'h6);
    held = got;
    // R10: inputs change with inValid low, result must hold
    opCode = 4'd13; operand = 64'hDEAD_BEEF_0000_1111; amtReg = 64'h7;
    @(negedge clk);
    check("R8 valid low", {63'b0, outValid}, 64'h0);
    check("R10 hold", result, held);

    // R1: upper operand bits ignored by word forms
    apply(4'd0, 64'hFFFF_0000_0000_0003, 5'd2, 64'h0, got, v);
    check("R1 upper ignored", got, 64'hC);
    // R4: bit 6 and above of amount register ignored by doubleword forms
    apply(4'd13, 64'h8000_0000_0000_0000, 5'd0, 64'hFFFF_FFFF_FFFF_FFC1, got, v);
    check("R4 mask", got, 64'h4000_0000_0000_0000);

    // R7: every code at key amounts with random operands
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 5; k++) begin
        logic [63:0] x;
        logic [63:0] a;
        logic [4:0]  imm;
        x   = {$urandom, $urandom};
        a   = {$urandom, $urandom};
        a[5:0] = 6'(amts[k]);
        imm = 5'(amts[k]);
        apply(4'(op), x, imm, a, got, v);
        check("R7 sweep", got, modelShift(4'(op), x, imm, a));
        check("R8 sweep valid", {63'b0, v}, 64'h1);
      end
    end

    summary();
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule